// File: doc/BRIEF.md
# Receive FIFO with Automatic Request-to-Send

This block buffers characters coming out of a serial receiver before a host collects them. Each of its 16 slots holds one 8-bit character together with three error flags that the receiver attached to it. The host pops slots with a read strobe, and the popped character is presented on a registered output. A write that arrives while every slot is taken is thrown away and sets a sticky overrun flag.

A two-bit trigger selector picks the fill level of interest: 1, 4, 8 or 14 characters. The same level drives two outputs. The first is an active-low receive-ready line that falls once the fill reaches the level, or when a timeout is signalled with data present. The second is an active-low request-to-send line that tells the remote transmitter to pause. When flow control is automatic, the three low levels release request-to-send at the threshold and hold it released until the FIFO drains completely. The 14 level instead releases it as the 16th character begins to arrive, which is the first data bit seen while 15 slots are full, and asserts it again as soon as the host frees a slot.

Top module: `rx_fifo_flow`

## Requirements
- R1: After reset the count is 0, `overrun` is 0, `rxrdy_n` is 1, `rd_data`/`rd_err` are 0, and `rts_n` equals the inverse of `rts_ctl`.
- R2: Characters and their error bits leave in the order in which they were accepted. The popped entry appears on `rd_data`/`rd_err` on the clock edge that samples the read strobe.
- R3: A write while the count is 16 and no read is popping is dropped, leaves the count at 16 and sets `overrun`. Any read strobe clears `overrun` unless a drop happens in the same cycle.
- R4: A read strobe while the FIFO is empty leaves `rd_data`, `rd_err` and the count unchanged.
- R5: A write and a read in the same cycle on a non-empty FIFO leave the count unchanged. This includes a full FIFO, where both are accepted.
- R6: `trig_sel` encodes the trigger level as 0 = 1, 1 = 4, 2 = 8 and 3 = 14 characters.
- R7: With automatic flow control and `trig_sel` 0 to 2, `rts_n` rises one cycle after the count reaches the trigger level. It stays high while any character remains, and falls one cycle after the count becomes 0.
- R8: With automatic flow control and `trig_sel` = 3, `first_bit` sampled while the count is 15 or 16 and no read pops makes `rts_n` high after that edge. The next popping read makes it low after its edge. `first_bit` at a lower count has no effect.
- R9: Automatic flow control needs `afe` = 1 and `rts_ctl` = 1. With `afe` = 0, `rts_n` is the inverse of `rts_ctl`. With `rts_ctl` = 0, `rts_n` is 1.
- R10: `rxrdy_n` falls one cycle after the count reaches the trigger level, or after the edge that samples `timeout` with a non-empty FIFO. It rises one cycle after the count becomes 0. A timeout on an empty FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags for the character |
| first_bit | input | 1 | Pulse: first data bit of an incoming character seen |
| rd_en | input | 1 | Host read strobe |
| timeout | input | 1 | Character timeout pulse |
| trig_sel | input | 2 | Trigger level selector |
| afe | input | 1 | Automatic flow control enable |
| rts_ctl | input | 1 | Host request-to-send control bit |
| rd_data | output | 8 | Last popped character |
| rd_err | output | 3 | Error flags of last popped character |
| count | output | 5 | Number of stored characters |
| overrun | output | 1 | Sticky dropped-write flag |
| rts_n | output | 1 | Request to send, active low |
| rxrdy_n | output | 1 | Receive ready, active low |

## Verification
The receiver write and the host read can land on the same edge. This matters most when all 16 slots are full, where the write must be accepted instead of dropped and the read must also assert request-to-send again under the 14 level. The bench drives both strobes in one step against a full FIFO. It then judges the unchanged count, the cleared overrun flag and the falling `rts_n`, while its scoreboard confirms that the character written in that cycle comes out last and in order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_ONE       = 2'd0,
    TRIG_QUARTER   = 2'd1,
    TRIG_HALF      = 2'd2,
    TRIG_NEAR_FULL = 2'd3
  } trig_sel_e;

  // Fill level that a trigger selector stands for, scaled to the depth.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    case (sel)
      TRIG_ONE:     return 1;
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      default:      return depth - 2;
    endcase
  endfunction

  // Circular pointer advance.
  function automatic int unsigned ptr_inc(input int unsigned p,
                                          input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int ENT_W = DATA_W + ERR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ENT_W-1:0] wr_ent,
  input  logic             rd_en,
  output logic [ENT_W-1:0] rd_ent,
  output logic [CNT_W-1:0] count,
  output logic             overrun,
  output logic             pop
);
  import rxq_pkg::*;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic empty, full, push, drop;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign pop   = rd_en && !empty;
  assign push  = wr_en && (!full || pop);
  assign drop  = wr_en && full && !pop;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      rd_ent  <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wp <= PTR_W'(ptr_inc(int'(wp), DEPTH));
      if (pop) begin
        rp     <= PTR_W'(ptr_inc(int'(rp), DEPTH));
        rd_ent <= mem[rp];
      end
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop)       overrun <= 1'b1;
      else if (rd_en) overrun <= 1'b0;
    end
  end

  // R3: a write with no room is lost and flagged
  p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (count == CNT_W'(DEPTH)) && overrun);

  // R4: reading an empty FIFO changes nothing
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> $stable(rd_ent) && (count == '0));

  // R5: paired read and write keep the level
  p_pair_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && !empty) |=> $stable(count));

endmodule

// File: rtl/rxq_rts.sv
module rxq_rts #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       trig_sel,
  input  logic             first_bit,
  input  logic             pop,
  input  logic             afe,
  input  logic             rts_ctl,
  output logic             rts_n
);
  import rxq_pkg::*;

  logic [CNT_W-1:0] trig_cnt;
  logic near_full_mode, hold, catch_last;

  assign trig_cnt       = CNT_W'(trig_level(trig_sel, DEPTH));
  assign near_full_mode = (trig_sel == TRIG_NEAR_FULL);
  // first bit of the character that will take the last free slot
  assign catch_last     = first_bit && (count >= CNT_W'(DEPTH - 1)) && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b0;
    end else if (near_full_mode) begin
      if (pop)             hold <= 1'b0;
      else if (catch_last) hold <= 1'b1;
    end else begin
      if (count >= trig_cnt)  hold <= 1'b1;
      else if (count == '0)   hold <= 1'b0;
    end
  end

  assign rts_n = !(rts_ctl && !(afe && hold));

  // R7: low triggers keep the request released until drained
  p_low_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!near_full_mode && hold && count != '0) |=> hold);

  // R8: near-full mode catches the last character and frees on a pop
  p_nf_catch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (near_full_mode && catch_last) |=> hold);
  p_nf_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (near_full_mode && pop) |=> !hold);

  // R9: with the control bit clear the request is never asserted
  p_noctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_ctl |-> rts_n);

endmodule

// File: rtl/rxq_ready.sv
module rxq_ready #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       trig_sel,
  input  logic             timeout,
  output logic             rxrdy_n
);
  import rxq_pkg::*;

  logic [CNT_W-1:0] trig_cnt;
  logic rdy;

  assign trig_cnt = CNT_W'(trig_level(trig_sel, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            rdy <= 1'b0;
    else if (count == '0)                  rdy <= 1'b0;
    else if (count >= trig_cnt || timeout) rdy <= 1'b1;
  end

  assign rxrdy_n = !rdy;

  // R10: empty FIFO releases the ready line
  p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> rxrdy_n);
  // R10: reaching the trigger level asserts the ready line
  p_trig_reach_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= trig_cnt) |=> !rxrdy_n);

endmodule

// File: rtl/rx_fifo_flow.sv
module rx_fifo_flow #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int ENT_W = DATA_W + ERR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  input  logic              first_bit,
  input  logic              rd_en,
  input  logic              timeout,
  input  logic [1:0]        trig_sel,
  input  logic              afe,
  input  logic              rts_ctl,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic [CNT_W-1:0]  count,
  output logic              overrun,
  output logic              rts_n,
  output logic              rxrdy_n
);

  logic [ENT_W-1:0] rd_ent;
  logic             pop;

  rxq_store #(.DATA_W(DATA_W), .ERR_W(ERR_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ent  ({wr_err, wr_data}),
    .rd_en   (rd_en),
    .rd_ent  (rd_ent),
    .count   (count),
    .overrun (overrun),
    .pop     (pop)
  );

  assign {rd_err, rd_data} = rd_ent;

  rxq_rts #(.DEPTH(DEPTH)) u_rts (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .trig_sel  (trig_sel),
    .first_bit (first_bit),
    .pop       (pop),
    .afe       (afe),
    .rts_ctl   (rts_ctl),
    .rts_n     (rts_n)
  );

  rxq_ready #(.DEPTH(DEPTH)) u_ready (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .trig_sel (trig_sel),
    .timeout  (timeout),
    .rxrdy_n  (rxrdy_n)
  );

endmodule

// File: tb/test_rx_fifo_flow.sv
module test_rx_fifo_flow;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, first_bit = 1'b0, rd_en = 1'b0, timeout = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_err = '0;
  logic [1:0] trig_sel = 2'd0;
  logic       afe = 1'b1, rts_ctl = 1'b1;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [4:0] count;
  logic       overrun, rts_n, rxrdy_n;

  int n_chk = 0, n_bad = 0, mdl_cnt = 0;
  logic [10:0] exp_q [$];
  bit done = 0;

  always #2 clk = ~clk;

  rx_fifo_flow i_rx_fifo_flow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .first_bit(first_bit), .rd_en(rd_en), .timeout(timeout), .trig_sel(trig_sel),
    .afe(afe), .rts_ctl(rts_ctl), .rd_data(rd_data), .rd_err(rd_err),
    .count(count), .overrun(overrun), .rts_n(rts_n), .rxrdy_n(rxrdy_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp_v);
    end
  endtask

  // Driver: applies one cycle of stimulus and records accepted characters.
  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] e,
                      input logic r, input logic fb, input logic to);
    logic pop_m, acc;
    wr_en = w; wr_data = d; wr_err = e; rd_en = r; first_bit = fb; timeout = to;
    pop_m = r && (mdl_cnt != 0);
    acc   = w && (mdl_cnt < 16 || pop_m);
    if (acc) exp_q.push_back({e, d});
    @(negedge clk);
    mdl_cnt = mdl_cnt + int'(acc) - int'(pop_m);
    wr_en = 0; rd_en = 0; first_bit = 0; timeout = 0;
  endtask

  task automatic idle();
    step(0, 8'h00, 3'd0, 0, 0, 0);
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] e);
    step(1, d, e, 0, 0, 0);
  endtask

  task automatic rd();
    step(0, 8'h00, 3'd0, 1, 0, 0);
  endtask

  // Monitor: compares each popped entry against the scoreboard queue (R2).
  always @(posedge clk) begin
    if (rst_n && rd_en && mdl_cnt != 0) begin
      #1;
      if (exp_q.size() == 0) check("R2 order (queue empty)", 32'(1), 32'(0));
      else check("R2 order", 32'({rd_err, rd_data}), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] saved;
    int lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(count), 32'(0));
    check("R1 overrun", 32'(overrun), 32'(0));
    check("R1 rxrdy_n", 32'(rxrdy_n), 32'(1));
    check("R1 rts_n", 32'(rts_n), 32'(0));
    check("R1 rd_data", 32'({rd_err, rd_data}), 32'(0));

    // R6/R7/R10 low triggers
    for (int s = 0; s < 3; s++) begin
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : 8;
      trig_sel = 2'(s);
      for (int i = 0; i < lvl - 1; i++) wr(8'(16 * s + i + 1), 3'(i));
      idle();
      check("R7 below trigger rts_n", 32'(rts_n), 32'(0));
      check("R10 below trigger rxrdy_n", 32'(rxrdy_n), 32'(1));
      wr(8'(16 * s + 15), 3'(s + 4));
      idle();
      check("R6 count at level", 32'(count), 32'(lvl));
      check("R7 at trigger rts_n", 32'(rts_n), 32'(1));
      check("R10 at trigger rxrdy_n", 32'(rxrdy_n), 32'(0));
      for (int i = 0; i < lvl - 1; i++) rd();
      idle();
      if (lvl > 1) check("R7 held until empty", 32'(rts_n), 32'(1));
      rd();
      idle();
      check("R7 drained rts_n", 32'(rts_n), 32'(0));
      check("R10 drained rxrdy_n", 32'(rxrdy_n), 32'(1));
    end

    // R8/R3/R5 near-full trigger
    trig_sel = 2'd3;
    for (int i = 0; i < 15; i++) wr(8'(8'hA0 + i), 3'(i + 1));
    idle();
    check("R8 15 stored rts_n", 32'(rts_n), 32'(0));
    check("R10 level 14 rxrdy_n", 32'(rxrdy_n), 32'(0));
    step(0, 8'h00, 3'd0, 0, 1, 0);
    check("R8 first bit of 16th", 32'(rts_n), 32'(1));
    wr(8'hC0, 3'd5);
    check("R5 full count", 32'(count), 32'(16));
    wr(8'hEE, 3'd7);
    check("R3 drop count", 32'(count), 32'(16));
    check("R3 overrun set", 32'(overrun), 32'(1));
    step(1, 8'hC1, 3'd6, 1, 0, 0);
    check("R5 pair at full count", 32'(count), 32'(16));
    check("R3 overrun cleared", 32'(overrun), 32'(0));
    check("R8 pop releases", 32'(rts_n), 32'(0));
    for (int i = 0; i < 6; i++) rd();
    step(0, 8'h00, 3'd0, 0, 1, 0);
    check("R8 first bit below 15 ignored", 32'(rts_n), 32'(0));
    for (int i = 0; i < 10; i++) rd();
    check("R4 drained", 32'(count), 32'(0));
    saved = {rd_err, rd_data};
    rd();
    check("R4 empty read data", 32'({rd_err, rd_data}), 32'(saved));
    check("R4 empty read count", 32'(count), 32'(0));

    // R5 paired read/write, not full
    wr(8'h33, 3'd1);
    step(1, 8'h44, 3'd2, 1, 0, 0);
    check("R5 pair count", 32'(count), 32'(1));
    rd();

    // R10 timeout
    wr(8'h51, 3'd0);
    wr(8'h52, 3'd0);
    idle();
    check("R10 below level", 32'(rxrdy_n), 32'(1));
    step(0, 8'h00, 3'd0, 0, 0, 1);
    check("R10 timeout asserts", 32'(rxrdy_n), 32'(0));
    rd(); rd(); idle();
    check("R10 empty releases", 32'(rxrdy_n), 32'(1));
    step(0, 8'h00, 3'd0, 0, 0, 1);
    check("R10 timeout on empty ignored", 32'(rxrdy_n), 32'(1));

    // R9 manual control
    afe = 1'b0; rts_ctl = 1'b0; idle();
    check("R9 manual off", 32'(rts_n), 32'(1));
    rts_ctl = 1'b1; trig_sel = 2'd0; wr(8'h61, 3'd3); idle();
    check("R9 manual on past trigger", 32'(rts_n), 32'(0));
    afe = 1'b1; rts_ctl = 1'b0; idle();
    check("R9 afe without ctl", 32'(rts_n), 32'(1));
    rts_ctl = 1'b1; idle();
    check("R9 auto held", 32'(rts_n), 32'(1));
    rd(); idle();
    check("R9 auto drained", 32'(rts_n), 32'(0));

    check("R2 queue drained", 32'(exp_q.size()), 32'(0));
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule